// File: doc/BRIEF.md
# Write-then-read dynamic fault RAM model

This block is a small bit-wide RAM model for memory-test work. It plants one dynamic fault that only shows up when a write is followed directly by a read of the same word. A test engine drives single-bit reads and writes through one operation port. A configuration port selects one of eight fault classes, a victim address, an aggressor address, and three polarity bits. The polarity bits are the aggressor state, the victim's state before the write, and the value that is written.

The model keeps a one-operation history. For each write it stores the address and an arm bit. The arm bit says whether that write met every precondition of the configured fault at the moment it was made. Idle cycles leave the history unchanged. Any read empties it, and so does a write that replaces it. When the next operation is a read of the recorded address and the arm bit is set, the configured effect is applied. Depending on the class, the effect inverts the stored cell, the returned value, or a coupled victim cell.

Top module: `dyn_wr_fault_ram`

## Requirements
- R1: After reset every cell is 0 and `rd_data` is 0. A write stores `op_wdata` at `op_addr`. A read places the stored bit on `rd_data` one clock after the read is taken. `rd_data` keeps its value until the next read.
- R2: A write and a read form a pair only if the read is the next operation after the write and both use the same address. Idle cycles (`op_valid` low) between them do not break the pair. A read of any address, or a write to a different address, placed between them cancels the pair.
- R3: Mode 1 (read disturb) fires when the victim held `cfg_y`, was written `cfg_z`, and is then read as a pair. The read returns the inverse of `cfg_z` and leaves the cell inverted.
- R4: Mode 2 (deceptive read disturb) uses the same conditions as R3. The read returns `cfg_z` but leaves the cell inverted.
- R5: Mode 3 (incorrect read) uses the same conditions as R3. The read returns the inverse of `cfg_z`, and the cell keeps `cfg_z`.
- R6: Mode 4 (disturb coupling) fires when the aggressor held `cfg_x` and the victim held `cfg_y`, and the aggressor is written `cfg_z` and then read as a pair. The victim cell inverts, and the aggressor read returns its correct value.
- R7: Modes 5, 6 and 7 behave like modes 1, 2 and 3 on the victim. In addition, each needs the aggressor cell to hold `cfg_x` when the write is made. Without that condition, no fault occurs.
- R8: If the cell's value before the write is not `cfg_y`, or the written data is not `cfg_z`, the pair behaves as fault-free.
- R9: `cfg_mode` 0 disables all faults. Modes 1 to 7 are encoded as listed in R3 to R7.
- R10: Each pair triggers at most one effect. A second read that directly follows returns the stored (possibly corrupted) cell with no further change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_we | input | 1 | 1 = write, 0 = read |
| op_addr | input | ADDR_W | Word address |
| op_wdata | input | 1 | Write data |
| cfg_mode | input | 3 | Fault class, 0 to 7 |
| cfg_victim | input | ADDR_W | Victim / faulty cell address |
| cfg_aggr | input | ADDR_W | Aggressor cell address |
| cfg_x | input | 1 | Required aggressor state |
| cfg_y | input | 1 | Required victim state before the write |
| cfg_z | input | 1 | Required written value |
| rd_data | output | 1 | Registered read data |

## Verification
A read value appears on `rd_data` one clock after the edge that takes the read. A corrupted cell caused by that same read only becomes visible through the next read, one operation later. The bench drives every operation on the falling edge and samples `rd_data` on the falling edge that follows the capturing rising edge. It confirms the state of each cell by issuing a later read rather than by looking inside the design. Pair-breaking cases place idle cycles, reads of other addresses, or foreign writes between the write and the read. The expected value for each case is taken from the requirements.

// File: rtl/wtr_pkg.sv
package wtr_pkg;
  typedef enum logic [2:0] {
    FM_NONE           = 3'd0,
    FM_RD_DISTURB     = 3'd1,
    FM_RD_DECEPT      = 3'd2,
    FM_RD_WRONG       = 3'd3,
    FM_CPL_DISTURB    = 3'd4,
    FM_CPL_RD_DISTURB = 3'd5,
    FM_CPL_RD_DECEPT  = 3'd6,
    FM_CPL_RD_WRONG   = 3'd7
  } fault_mode_e;
endpackage

// File: rtl/wtr_history.sv
module wtr_history #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              arm_in,
  output logic              hist_valid,
  output logic              hist_armed,
  output logic [ADDR_W-1:0] hist_addr
);
  logic              valid_d, armed_d;
  logic [ADDR_W-1:0] addr_d;
  logic              hist_en;

  assign hist_en = op_valid;

  always_comb begin
    if (op_we) begin
      valid_d = 1'b1;
      armed_d = arm_in;
      addr_d  = op_addr;
    end else begin
      valid_d = 1'b0;
      armed_d = 1'b0;
      addr_d  = hist_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_valid <= 1'b0;
      hist_armed <= 1'b0;
      hist_addr  <= '0;
    end else if (hist_en) begin
      hist_valid <= valid_d;
      hist_armed <= armed_d;
      hist_addr  <= addr_d;
    end
  end
endmodule

// File: rtl/wtr_fault_ctl.sv
module wtr_fault_ctl
  import wtr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  fault_mode_e       mode,
  input  logic [ADDR_W-1:0] cfg_victim,
  input  logic [ADDR_W-1:0] cfg_aggr,
  input  logic              cfg_x,
  input  logic              cfg_y,
  input  logic              cfg_z,
  input  logic              op_valid,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_wdata,
  input  logic [DEPTH-1:0]  cells,
  input  logic              hist_valid,
  input  logic              hist_armed,
  input  logic [ADDR_W-1:0] hist_addr,
  output logic              arm_next,
  output logic              flip_en,
  output logic [ADDR_W-1:0] flip_addr,
  output logic              rd_invert
);
  logic is_wr, is_rd, at_vict, at_aggr, vict_ok, aggr_ok, data_ok, fire;

  always_comb begin
    is_wr   = op_valid & op_we;
    is_rd   = op_valid & ~op_we;
    at_vict = (op_addr == cfg_victim);
    at_aggr = (op_addr == cfg_aggr);
    vict_ok = (cells[cfg_victim] == cfg_y);
    aggr_ok = (cells[cfg_aggr] == cfg_x);
    data_ok = (op_wdata == cfg_z);
    fire    = is_rd & hist_valid & hist_armed & (hist_addr == op_addr);

    arm_next = 1'b0;
    unique case (mode)
      FM_RD_DISTURB, FM_RD_DECEPT, FM_RD_WRONG:
        arm_next = is_wr & at_vict & vict_ok & data_ok;
      FM_CPL_DISTURB:
        arm_next = is_wr & at_aggr & aggr_ok & vict_ok & data_ok;
      FM_CPL_RD_DISTURB, FM_CPL_RD_DECEPT, FM_CPL_RD_WRONG:
        arm_next = is_wr & at_vict & aggr_ok & vict_ok & data_ok;
      default: arm_next = 1'b0;
    endcase

    flip_en   = 1'b0;
    flip_addr = op_addr;
    rd_invert = 1'b0;
    if (fire) begin
      unique case (mode)
        FM_RD_DISTURB, FM_CPL_RD_DISTURB: begin
          flip_en   = 1'b1;
          rd_invert = 1'b1;
        end
        FM_RD_DECEPT, FM_CPL_RD_DECEPT: flip_en = 1'b1;
        FM_RD_WRONG, FM_CPL_RD_WRONG:   rd_invert = 1'b1;
        FM_CPL_DISTURB: begin
          flip_en   = 1'b1;
          flip_addr = cfg_victim;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wtr_cell_array.sv
module wtr_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic              flip_en,
  input  logic [ADDR_W-1:0] flip_addr,
  output logic [DEPTH-1:0]  cells
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic sel_wr, sel_flip, cell_en, cell_d;

    always_comb begin
      sel_wr   = wr_en   && (wr_addr   == ADDR_W'(i));
      sel_flip = flip_en && (flip_addr == ADDR_W'(i));
      cell_en  = sel_wr | sel_flip;
      cell_d   = sel_wr ? wr_data : ~cells[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells[i] <= 1'b0;
      else if (cell_en) cells[i] <= cell_d;
    end
  end
endmodule

// File: rtl/dyn_wr_fault_ram.sv
module dyn_wr_fault_ram
  import wtr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_wdata,
  input  logic [2:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_victim,
  input  logic [ADDR_W-1:0] cfg_aggr,
  input  logic              cfg_x,
  input  logic              cfg_y,
  input  logic              cfg_z,
  output logic              rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  cells;
  logic              hist_valid, hist_armed;
  logic [ADDR_W-1:0] hist_addr;
  logic              arm_next, flip_en, rd_invert;
  logic [ADDR_W-1:0] flip_addr;
  logic              rd_en, rd_d;
  fault_mode_e       mode;

  assign mode = fault_mode_e'(cfg_mode);

  wtr_history #(.ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_we(op_we),
    .op_addr(op_addr), .arm_in(arm_next), .hist_valid(hist_valid),
    .hist_armed(hist_armed), .hist_addr(hist_addr)
  );

  wtr_fault_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctl (
    .mode(mode), .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_z(cfg_z), .op_valid(op_valid),
    .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata), .cells(cells),
    .hist_valid(hist_valid), .hist_armed(hist_armed), .hist_addr(hist_addr),
    .arm_next(arm_next), .flip_en(flip_en), .flip_addr(flip_addr),
    .rd_invert(rd_invert)
  );

  wtr_cell_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(op_valid & op_we), .wr_addr(op_addr),
    .wr_data(op_wdata), .flip_en(flip_en), .flip_addr(flip_addr),
    .cells(cells)
  );

  assign rd_en = op_valid & ~op_we;
  assign rd_d  = cells[op_addr] ^ rd_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 1'b0;
    else if (rd_en) rd_data <= rd_d;
  end
endmodule

// File: rtl/dyn_wr_fault_ram_chk.sv
module dyn_wr_fault_ram_chk #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_we,
  input logic [ADDR_W-1:0] op_addr,
  input logic              op_wdata,
  input logic [2:0]        cfg_mode,
  input logic              rd_data,
  input logic [DEPTH-1:0]  cells,
  input logic              hist_valid
);
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && !op_we) |=> $stable(rd_data)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_we) |=> cells[$past(op_addr)] == $past(op_wdata)); // R1

  AST_READ_ENDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_we) |=> !hist_valid); // R2

  AST_WRONG_READ_KEEPS_CELLS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_we && (cfg_mode == 3'd3 || cfg_mode == 3'd7)) |=> $stable(cells)); // R5

  AST_CLEAN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0 && op_valid && !op_we && $past(op_valid && op_we)
     && $past(op_addr) == op_addr) |=> rd_data == $past(op_wdata, 2)); // R9

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_we) |=> $countones(cells ^ $past(cells)) <= 1); // R10
endmodule

bind dyn_wr_fault_ram dyn_wr_fault_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_we(op_we),
  .op_addr(op_addr), .op_wdata(op_wdata), .cfg_mode(cfg_mode),
  .rd_data(rd_data), .cells(cells), .hist_valid(hist_valid)
);

// File: tb/dyn_wr_fault_ram_tb.sv
`timescale 1ns/1ps
module dyn_wr_fault_ram_tb;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid, op_we, op_wdata;
  logic [AW-1:0] op_addr, cfg_victim, cfg_aggr;
  logic [2:0]    cfg_mode;
  logic          cfg_x, cfg_y, cfg_z;
  logic          rd_data;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  dyn_wr_fault_ram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_we(op_we),
    .op_addr(op_addr), .op_wdata(op_wdata), .cfg_mode(cfg_mode),
    .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr), .cfg_x(cfg_x),
    .cfg_y(cfg_y), .cfg_z(cfg_z), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] m, input logic [AW-1:0] v,
                     input logic [AW-1:0] a, input logic x, input logic y,
                     input logic z);
    cfg_mode = m; cfg_victim = v; cfg_aggr = a; cfg_x = x; cfg_y = y; cfg_z = z;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic d);
    op_valid = 1'b1; op_we = 1'b1; op_addr = a; op_wdata = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic q);
    op_valid = 1'b1; op_we = 1'b0; op_addr = a;
    @(negedge clk);
    op_valid = 1'b0;
    q = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_and_plain();
    logic q;
    check("R1 reset rd_data", rd_data, 1'b0);
    rd(4'd3, q); check("R1 reset cell", q, 1'b0);
    wr(4'd5, 1'b1); idle(1); wr(4'd6, 1'b0);
    rd(4'd5, q); check("R1 stored 1", q, 1'b1);
    idle(2); check("R1 rd_data held", rd_data, 1'b1);
    rd(4'd6, q); check("R1 stored 0", q, 1'b0);
  endtask

  task automatic t_mode_none();
    logic q;
    cfg(3'd0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd0, 1'b1); rd(4'd0, q); check("R9 mode 0 no fault", q, 1'b1);
  endtask

  task automatic t_single_cell();
    logic q;
    cfg(3'd1, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd2, 1'b1); rd(4'd2, q); check("R3 disturb read", q, 1'b0);
    rd(4'd2, q); check("R10 R3 cell inverted once", q, 1'b0);
    cfg(3'd2, 4'd3, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd3, 1'b1); rd(4'd3, q); check("R4 deceptive read", q, 1'b1);
    rd(4'd3, q); check("R4 cell inverted", q, 1'b0);
    cfg(3'd3, 4'd4, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd4, 1'b1); rd(4'd4, q); check("R5 wrong read", q, 1'b0);
    rd(4'd4, q); check("R5 cell kept", q, 1'b1);
  endtask

  task automatic t_pairing();
    logic q;
    cfg(3'd1, 4'd7, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd7, 1'b1); idle(3); rd(4'd7, q); check("R2 idle keeps pair", q, 1'b0);
    cfg(3'd1, 4'd8, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd8, 1'b1); wr(4'd9, 1'b0); rd(4'd8, q);
    check("R2 foreign write breaks pair", q, 1'b1);
    cfg(3'd1, 4'd10, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd10, 1'b1); rd(4'd11, q); rd(4'd10, q);
    check("R2 foreign read breaks pair", q, 1'b1);
  endtask

  task automatic t_mismatch();
    logic q;
    cfg(3'd0, 4'd12, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd12, 1'b1);
    cfg(3'd1, 4'd12, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd12, 1'b1); rd(4'd12, q); check("R8 prior state mismatch", q, 1'b1);
    cfg(3'd1, 4'd11, 4'd1, 1'b0, 1'b0, 1'b1);
    wr(4'd11, 1'b0); rd(4'd11, q); check("R8 written value mismatch", q, 1'b0);
  endtask

  task automatic t_coupling();
    logic q;
    cfg(3'd4, 4'd14, 4'd13, 1'b0, 1'b0, 1'b1);
    wr(4'd13, 1'b1); rd(4'd13, q); check("R6 aggressor read correct", q, 1'b1);
    rd(4'd14, q); check("R6 victim flipped", q, 1'b1);
    cfg(3'd0, 4'd1, 4'd15, 1'b1, 1'b0, 1'b1);
    wr(4'd15, 1'b1);
    cfg(3'd5, 4'd1, 4'd15, 1'b1, 1'b0, 1'b1);
    wr(4'd1, 1'b1); rd(4'd1, q); check("R7 coupled disturb read", q, 1'b0);
    rd(4'd1, q); check("R7 coupled disturb cell", q, 1'b0);
    cfg(3'd7, 4'd1, 4'd15, 1'b0, 1'b0, 1'b1);
    wr(4'd1, 1'b1); rd(4'd1, q); check("R7 aggressor state gates fault", q, 1'b1);
    cfg(3'd7, 4'd1, 4'd15, 1'b1, 1'b1, 1'b0);
    wr(4'd1, 1'b0); rd(4'd1, q); check("R7 coupled wrong read", q, 1'b1);
    rd(4'd1, q); check("R7 coupled wrong read cell kept", q, 1'b0);
    cfg(3'd6, 4'd1, 4'd15, 1'b1, 1'b0, 1'b1);
    wr(4'd1, 1'b1); rd(4'd1, q); check("R7 coupled deceptive read", q, 1'b1);
    rd(4'd1, q); check("R7 coupled deceptive cell", q, 1'b0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog got=hang exp=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_we = 1'b0; op_addr = '0; op_wdata = 1'b0;
    cfg(3'd0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_plain();
    t_mode_none();
    t_single_cell();
    t_pairing();
    t_mismatch();
    t_coupling();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule